// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command front end of a NOR-style flash device. All bus inputs are sampled on a core clock. The block watches a bus made of chip enables, write enable, output enable and an address and data bus. It decodes the command bytes written over that bus and chooses what a read returns: array data, the identifier words or the status byte. It also launches program and block-erase operations on an abstract array engine, reports busy through a ready/busy pin, and handles power-down.

A write is taken when its write phase closes. That happens when write enable or the chip enable group goes inactive, whichever comes first, and the address and data captured in the last active cycle are used. A power-down input forces the outputs off and aborts any running operation. On leaving power-down the controller holds the ready pin low for a set number of cycles. It refuses commands for a longer, separate recovery window, then starts in read-array mode with a status byte of 0x80.

Top module: `flash_cmd_if`

## Requirements
- R1: After the synchronous reset `rst`, the controller is in read-array mode with status 0x80. `rdy_o` is low until `BUSY_CYC` cycles have passed and high after that.
- R2: Writing 0xFF selects array reads (`dq_out` = `arr_rdata`). Writing 0x90 selects identifier reads: `addr[0]`=0 gives `MFR_ID` and `addr[0]`=1 gives `DEV_ID`. Writing 0x70 selects status reads, with the status byte in `dq_out[7:0]` and zeros above it. None of these depends on `pen`.
- R3: A bus write takes effect only if every bit of `ce_n` is low, `we_n` is low, `oe_n` is high and `pd_n` is high for the whole write phase. A write made with `oe_n` low or with any chip enable high has no effect.
- R4: The address and data of a write are those present in the last cycle before the write phase ends. The phase ends when `we_n` rises or any `ce_n` bit rises, whichever happens first. Changes after that point are not used.
- R5: Writing 0x40 and then a data write with `pen` high pulses `eng_start` for one cycle, with `eng_erase`=0 and the second write's address and data on `eng_addr` and `eng_data`. `rdy_o` and status bit 7 stay low until `eng_done`, and reads return status until then.
- R6: Writing 0x20 and then 0xD0 with `pen` high pulses `eng_start` with `eng_erase`=1 and the confirm write's address.
- R7: If `pen` is low when the second write of a program or erase arrives, no operation starts. Status bit 3 is set, together with bit 4 for a program or bit 5 for an erase, and the mode becomes status read.
- R8: Writing 0x20 followed by any byte other than 0xD0 starts nothing. It sets status bits 5 and 4 and selects status read.
- R9: Writing 0x50 clears status bits 5, 4 and 3 and leaves the read mode unchanged.
- R10: If `eng_fail` is high when `eng_done` arrives, the controller sets status bit 4 after a program or bit 5 after an erase. In both cases bit 7 returns high and the mode is status read.
- R11: While `pd_n` is low, `dq_oe` and `rdy_o` are low and `eng_abort` is high. After `pd_n` rises, the controller is in read-array mode with status 0x80, and the aborted operation leaves no error bits.
- R12: After `pd_n` rises, `rdy_o` stays low for exactly `BUSY_CYC` cycles. Writes that complete within the first `REC_CYC` cycles are ignored.
- R13: Once an operation has started, the controller stays busy and ignores writes until `eng_done`, even if the chip enables go inactive. Completion is recorded while the device is deselected.
- R14: `dq_oe` is high only when all `ce_n` bits are low, `oe_n` is low, `we_n` is high and `pd_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| ce_n | input | NCE | Chip enables, all low to select |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| pd_n | input | 1 | Power-down, active low |
| pen | input | 1 | Program-enable level |
| addr | input | AW | Bus address |
| dq_in | input | DW | Bus write data |
| dq_out | output | DW | Bus read data |
| dq_oe | output | 1 | Read data drive enable |
| rdy_o | output | 1 | Ready/busy status, high when ready |
| arr_addr | output | AW | Array read address |
| arr_rdata | input | DW | Array read data |
| eng_start | output | 1 | One-cycle operation start |
| eng_erase | output | 1 | Operation kind, 1 = block erase, 0 = program |
| eng_addr | output | AW | Operation address |
| eng_data | output | DW | Program data |
| eng_done | input | 1 | Operation finished |
| eng_fail | input | 1 | Operation failed, valid with eng_done |
| eng_abort | output | 1 | Abort request to the engine |

## Verification
A wrong mode register shows up on the next read cycle. The read returns array data where identifier or status was expected, or the reverse, and the wrong value is on `dq_out` as soon as the read begins. A stale or missing error bit appears only when the status byte is read back, so each error path is followed by a status read and by a clear with 0x50. A miscounted recovery counter moves the rise of `rdy_o` by one or more cycles, or lets a command through during recovery. Both are caught by checking `rdy_o` on the exact cycle where it should change, and by reading the mode back after a write made inside the recovery window.

// File: rtl/flash_ci_pkg.sv
package flash_ci_pkg;

    localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
    localparam logic [7:0] CMD_READ_IDENT = 8'h90;
    localparam logic [7:0] CMD_READ_STAT  = 8'h70;
    localparam logic [7:0] CMD_CLR_STAT   = 8'h50;
    localparam logic [7:0] CMD_PROGRAM    = 8'h40;
    localparam logic [7:0] CMD_ERASE      = 8'h20;
    localparam logic [7:0] CMD_CONFIRM    = 8'hD0;

    typedef enum logic [2:0] {
        M_ARRAY,
        M_IDENT,
        M_STATUS,
        M_PROG_WAIT,
        M_ERASE_WAIT,
        M_BUSY
    } mode_e;

    typedef struct packed {
        logic       ready;
        logic       rsv6;
        logic       erase_err;
        logic       prog_err;
        logic       pen_low;
        logic [2:0] rsv;
    } stat_t;

    function automatic logic all_low(input logic [7:0] v, input int n);
        logic r;
        r = 1'b1;
        for (int i = 0; i < 8; i++) begin
            if (i < n && v[i]) r = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/fci_reset_seq.sv
module fci_reset_seq #(
    parameter int REC_CYC  = 12,
    parameter int BUSY_CYC = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic pd_n,
    output logic cmd_ok,
    output logic rst_busy
);
    localparam int CMAX = (REC_CYC > BUSY_CYC) ? REC_CYC : BUSY_CYC;
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] REC_L  = CW'(REC_CYC);
    localparam logic [CW-1:0] BUSY_L = CW'(BUSY_CYC);
    localparam logic [CW-1:0] MAX_L  = CW'(CMAX);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !pd_n) begin
            cnt_q <= '0;
        end else if (cnt_q != MAX_L) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cmd_ok   = pd_n && (cnt_q >= REC_L);
    assign rst_busy = !pd_n || (cnt_q < BUSY_L);
endmodule

// File: rtl/fci_bus_capture.sv
module fci_bus_capture #(
    parameter int AW  = 24,
    parameter int DW  = 16,
    parameter int NCE = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCE-1:0] ce_n,
    input  logic           we_n,
    input  logic           oe_n,
    input  logic           pd_n,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  dq_in,
    output logic           commit,
    output logic [AW-1:0]  cap_addr,
    output logic [DW-1:0]  cap_data
);
    logic selected;
    logic wr_now;
    logic wr_q;

    assign selected = (ce_n == '0);
    assign wr_now   = pd_n && selected && !we_n && oe_n;

    always_ff @(posedge clk) begin
        if (rst || !pd_n) begin
            wr_q     <= 1'b0;
            cap_addr <= '0;
            cap_data <= '0;
        end else begin
            wr_q <= wr_now;
            if (wr_now) begin
                cap_addr <= addr;
                cap_data <= dq_in;
            end
        end
    end

    assign commit = wr_q && !wr_now;
endmodule

// File: rtl/fci_cmd_fsm.sv
module fci_cmd_fsm
    import flash_ci_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pd_n,
    input  logic          pen,
    input  logic          commit,
    input  logic [AW-1:0] cap_addr,
    input  logic [DW-1:0] cap_data,
    input  logic          eng_done,
    input  logic          eng_fail,
    output mode_e         mode,
    output stat_t         status,
    output logic          eng_start,
    output logic          eng_erase,
    output logic [AW-1:0] eng_addr,
    output logic [DW-1:0] eng_data
);
    mode_e         mode_q;
    logic          err_erase_q, err_prog_q, err_pen_q;
    logic          op_erase_q, start_q;
    logic [AW-1:0] ea_q;
    logic [DW-1:0] ed_q;
    logic [7:0]    cmd;

    assign cmd = cap_data[7:0];

    always_ff @(posedge clk) begin
        if (rst || !pd_n) begin
            mode_q      <= M_ARRAY;
            err_erase_q <= 1'b0;
            err_prog_q  <= 1'b0;
            err_pen_q   <= 1'b0;
            op_erase_q  <= 1'b0;
            start_q     <= 1'b0;
            ea_q        <= '0;
            ed_q        <= '0;
        end else begin
            start_q <= 1'b0;
            if (mode_q == M_BUSY) begin
                if (eng_done) begin
                    mode_q <= M_STATUS;
                    if (eng_fail) begin
                        if (op_erase_q) err_erase_q <= 1'b1;
                        else            err_prog_q  <= 1'b1;
                    end
                end
            end else if (commit) begin
                case (mode_q)
                    M_PROG_WAIT: begin
                        if (pen) begin
                            mode_q     <= M_BUSY;
                            start_q    <= 1'b1;
                            op_erase_q <= 1'b0;
                            ea_q       <= cap_addr;
                            ed_q       <= cap_data;
                        end else begin
                            mode_q     <= M_STATUS;
                            err_prog_q <= 1'b1;
                            err_pen_q  <= 1'b1;
                        end
                    end
                    M_ERASE_WAIT: begin
                        if (cmd != CMD_CONFIRM) begin
                            mode_q      <= M_STATUS;
                            err_erase_q <= 1'b1;
                            err_prog_q  <= 1'b1;
                        end else if (pen) begin
                            mode_q     <= M_BUSY;
                            start_q    <= 1'b1;
                            op_erase_q <= 1'b1;
                            ea_q       <= cap_addr;
                            ed_q       <= '0;
                        end else begin
                            mode_q      <= M_STATUS;
                            err_erase_q <= 1'b1;
                            err_pen_q   <= 1'b1;
                        end
                    end
                    default: begin
                        case (cmd)
                            CMD_READ_ARRAY: mode_q <= M_ARRAY;
                            CMD_READ_IDENT: mode_q <= M_IDENT;
                            CMD_READ_STAT:  mode_q <= M_STATUS;
                            CMD_PROGRAM:    mode_q <= M_PROG_WAIT;
                            CMD_ERASE:      mode_q <= M_ERASE_WAIT;
                            CMD_CLR_STAT: begin
                                err_erase_q <= 1'b0;
                                err_prog_q  <= 1'b0;
                                err_pen_q   <= 1'b0;
                            end
                            default: mode_q <= mode_q;
                        endcase
                    end
                endcase
            end
        end
    end

    always_comb begin
        status           = '0;
        status.ready     = (mode_q != M_BUSY);
        status.erase_err = err_erase_q;
        status.prog_err  = err_prog_q;
        status.pen_low   = err_pen_q;
    end

    assign mode      = mode_q;
    assign eng_start = start_q;
    assign eng_erase = op_erase_q;
    assign eng_addr  = ea_q;
    assign eng_data  = ed_q;
endmodule

// File: rtl/fci_read_mux.sv
module fci_read_mux
    import flash_ci_pkg::*;
#(
    parameter int          DW     = 16,
    parameter int          NCE    = 3,
    parameter logic [15:0] MFR_ID = 16'h005A,
    parameter logic [15:0] DEV_ID = 16'h0B17
) (
    input  mode_e          mode,
    input  stat_t          status,
    input  logic           addr_lsb,
    input  logic [DW-1:0]  arr_rdata,
    input  logic [NCE-1:0] ce_n,
    input  logic           oe_n,
    input  logic           we_n,
    input  logic           pd_n,
    output logic [DW-1:0]  dq_out,
    output logic           dq_oe
);
    localparam logic [DW-1:0] MFR_W = DW'(MFR_ID);
    localparam logic [DW-1:0] DEV_W = DW'(DEV_ID);

    always_comb begin
        case (mode)
            M_ARRAY: dq_out = arr_rdata;
            M_IDENT: dq_out = addr_lsb ? DEV_W : MFR_W;
            default: dq_out = DW'(status);
        endcase
    end

    assign dq_oe = pd_n && (ce_n == '0) && !oe_n && we_n;
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
    import flash_ci_pkg::*;
#(
    parameter int          AW       = 24,
    parameter int          DW       = 16,
    parameter int          NCE      = 3,
    parameter int          REC_CYC  = 12,
    parameter int          BUSY_CYC = 5,
    parameter logic [15:0] MFR_ID   = 16'h005A,
    parameter logic [15:0] DEV_ID   = 16'h0B17
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCE-1:0] ce_n,
    input  logic           we_n,
    input  logic           oe_n,
    input  logic           pd_n,
    input  logic           pen,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  dq_in,
    output logic [DW-1:0]  dq_out,
    output logic           dq_oe,
    output logic           rdy_o,
    output logic [AW-1:0]  arr_addr,
    input  logic [DW-1:0]  arr_rdata,
    output logic           eng_start,
    output logic           eng_erase,
    output logic [AW-1:0]  eng_addr,
    output logic [DW-1:0]  eng_data,
    input  logic           eng_done,
    input  logic           eng_fail,
    output logic           eng_abort
);
    logic          cmd_ok, rst_busy, commit;
    logic [AW-1:0] cap_addr;
    logic [DW-1:0] cap_data;
    mode_e         mode;
    stat_t         status;

    fci_reset_seq #(.REC_CYC(REC_CYC), .BUSY_CYC(BUSY_CYC)) u_rseq (
        .clk(clk), .rst(rst), .pd_n(pd_n), .cmd_ok(cmd_ok), .rst_busy(rst_busy)
    );

    fci_bus_capture #(.AW(AW), .DW(DW), .NCE(NCE)) u_cap (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .pd_n(pd_n),
        .addr(addr), .dq_in(dq_in), .commit(commit),
        .cap_addr(cap_addr), .cap_data(cap_data)
    );

    fci_cmd_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk(clk), .rst(rst), .pd_n(pd_n), .pen(pen),
        .commit(commit && cmd_ok), .cap_addr(cap_addr), .cap_data(cap_data),
        .eng_done(eng_done), .eng_fail(eng_fail),
        .mode(mode), .status(status),
        .eng_start(eng_start), .eng_erase(eng_erase),
        .eng_addr(eng_addr), .eng_data(eng_data)
    );

    fci_read_mux #(.DW(DW), .NCE(NCE), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_rmux (
        .mode(mode), .status(status), .addr_lsb(addr[0]), .arr_rdata(arr_rdata),
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .pd_n(pd_n),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    assign rdy_o     = pd_n && !rst_busy && status.ready;
    assign eng_abort = !pd_n;
    assign arr_addr  = addr;
endmodule

// File: rtl/flash_cmd_if_chk.sv
module flash_cmd_if_chk #(
    parameter int BUSY_CYC = 5
) (
    input logic clk,
    input logic rst,
    input logic pd_n,
    input logic pen,
    input logic rdy_o,
    input logic dq_oe,
    input logic eng_start,
    input logic eng_abort
);
    logic [15:0] up_cnt;

    always_ff @(posedge clk) begin
        if (rst || !pd_n) up_cnt <= '0;
        else if (up_cnt < 16'(BUSY_CYC)) up_cnt <= up_cnt + 16'd1;
    end

    // R11
    pd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !pd_n |-> (!rdy_o && !dq_oe && eng_abort));

    // R12
    rst_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (up_cnt < 16'(BUSY_CYC)) |-> !rdy_o);

    // R5
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> !rdy_o);

    // R7
    start_pen_chk: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> $past(pen));

    // R5
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);
endmodule

bind flash_cmd_if flash_cmd_if_chk #(.BUSY_CYC(BUSY_CYC)) u_chk (
    .clk(clk), .rst(rst), .pd_n(pd_n), .pen(pen), .rdy_o(rdy_o),
    .dq_oe(dq_oe), .eng_start(eng_start), .eng_abort(eng_abort)
);

// File: tb/flash_cmd_if_tb.sv
module flash_cmd_if_tb;
    localparam int AW = 24;
    localparam int DW = 16;
    localparam int REC_CYC = 12;
    localparam int BUSY_CYC = 5;
    localparam logic [15:0] MFR = 16'h005A;
    localparam logic [15:0] DEV = 16'h0B17;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] ce_n = 3'b111;
    logic we_n = 1'b1, oe_n = 1'b1, pd_n = 1'b1, pen = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic dq_oe, rdy_o;
    logic [AW-1:0] arr_addr;
    logic [DW-1:0] arr_rdata;
    logic eng_start, eng_erase, eng_abort;
    logic [AW-1:0] eng_addr;
    logic [DW-1:0] eng_data;
    logic eng_done = 1'b0, eng_fail = 1'b0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    assign arr_rdata = arr_addr[15:0] ^ 16'hA5A5;

    flash_cmd_if u_dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .pd_n(pd_n),
        .pen(pen), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .rdy_o(rdy_o), .arr_addr(arr_addr), .arr_rdata(arr_rdata),
        .eng_start(eng_start), .eng_erase(eng_erase), .eng_addr(eng_addr),
        .eng_data(eng_data), .eng_done(eng_done), .eng_fail(eng_fail),
        .eng_abort(eng_abort)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic raw_write(input logic [2:0] ce, input logic oe, input logic [AW-1:0] a,
                             input logic [DW-1:0] d);
        @(negedge clk);
        ce_n = ce; oe_n = oe; we_n = 1'b0; addr = a; dq_in = d;
        @(negedge clk);
        @(negedge clk);
        we_n = 1'b1; ce_n = 3'b111; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        raw_write(3'b000, 1'b1, a, d);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic oe);
        @(negedge clk);
        ce_n = 3'b000; oe_n = 1'b0; addr = a;
        #1;
        d = dq_out; oe = dq_oe;
        @(negedge clk);
        ce_n = 3'b111; oe_n = 1'b1;
    endtask

    task automatic finish_op(input logic fail);
        @(negedge clk);
        eng_done = 1'b1; eng_fail = fail;
        @(negedge clk);
        eng_done = 1'b0; eng_fail = 1'b0;
    endtask

    task automatic t_reset;
        logic [DW-1:0] d; logic oe;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1 chk("R1 rdy low after reset", 32'(rdy_o), 32'd0);
        repeat (REC_CYC + 2) @(negedge clk);
        chk("R1 rdy high after busy time", 32'(rdy_o), 32'd1);
        rd(24'h000005, d, oe);
        chk("R1 array mode at start", 32'(d), 32'(16'h0005 ^ 16'hA5A5));
        chk("R14 output enabled on read", 32'(oe), 32'd1);
        wr(24'h0, 16'h0070);
        rd(24'h0, d, oe);
        chk("R1 initial status", 32'(d), 32'h80);
    endtask

    task automatic t_modes;
        logic [DW-1:0] d; logic oe;
        pen = 1'b0;
        wr(24'h0, 16'h0090);
        rd(24'h000000, d, oe);
        chk("R2 manufacturer id", 32'(d), 32'(MFR));
        rd(24'h000001, d, oe);
        chk("R2 device id", 32'(d), 32'(DEV));
        wr(24'h0, 16'h0070);
        rd(24'h000001, d, oe);
        chk("R2 status mode", 32'(d), 32'h80);
        wr(24'h0, 16'h00FF);
        rd(24'h001234, d, oe);
        chk("R2 array mode", 32'(d), 32'(16'h1234 ^ 16'hA5A5));
        pen = 1'b1;
        @(negedge clk);
        ce_n = 3'b000; oe_n = 1'b1; we_n = 1'b1;
        #1 chk("R14 no drive with oe high", 32'(dq_oe), 32'd0);
        ce_n = 3'b010; oe_n = 1'b0;
        #1 chk("R14 no drive with one enable high", 32'(dq_oe), 32'd0);
        ce_n = 3'b111; oe_n = 1'b1;
    endtask

    task automatic t_gating;
        logic [DW-1:0] d; logic oe;
        raw_write(3'b000, 1'b0, 24'h0, 16'h0090);
        rd(24'h000001, d, oe);
        chk("R3 write with oe low ignored", 32'(d), 32'(16'h0001 ^ 16'hA5A5));
        raw_write(3'b100, 1'b1, 24'h0, 16'h0090);
        rd(24'h000001, d, oe);
        chk("R3 write with enable high ignored", 32'(d), 32'(16'h0001 ^ 16'hA5A5));
    endtask

    task automatic t_capture;
        logic [DW-1:0] d; logic oe;
        wr(24'h0, 16'h0040);
        @(negedge clk);
        ce_n = 3'b000; we_n = 1'b0; addr = 24'h012345; dq_in = 16'h5AA5;
        @(negedge clk); @(negedge clk);
        we_n = 1'b1; addr = 24'hFEDCBA; dq_in = 16'h1111;
        @(negedge clk);
        ce_n = 3'b111;
        @(negedge clk);
        chk("R4 we first address", 32'(eng_addr), 32'h012345);
        chk("R4 we first data", 32'(eng_data), 32'h5AA5);
        chk("R5 busy during program", 32'(rdy_o), 32'd0);
        rd(24'h0, d, oe);
        chk("R5 status busy read", 32'(d), 32'h00);
        finish_op(1'b0);
        chk("R5 ready after done", 32'(rdy_o), 32'd1);
        wr(24'h0, 16'h0040);
        @(negedge clk);
        ce_n = 3'b000; we_n = 1'b0; addr = 24'h00ABCD; dq_in = 16'h3C3C;
        @(negedge clk); @(negedge clk);
        ce_n = 3'b011; addr = 24'h777777; dq_in = 16'h9999;
        @(negedge clk);
        we_n = 1'b1; ce_n = 3'b111;
        @(negedge clk);
        chk("R4 ce first address", 32'(eng_addr), 32'h00ABCD);
        chk("R4 ce first data", 32'(eng_data), 32'h3C3C);
        finish_op(1'b0);
    endtask

    task automatic t_program;
        logic [DW-1:0] d; logic oe;
        wr(24'h0, 16'h0040);
        wr(24'h000200, 16'hBEEF);
        chk("R5 start pulse", 32'(eng_start), 32'd1);
        chk("R5 program kind", 32'(eng_erase), 32'd0);
        chk("R5 program data", 32'(eng_data), 32'hBEEF);
        @(negedge clk);
        chk("R5 start one cycle", 32'(eng_start), 32'd0);
        finish_op(1'b1);
        rd(24'h0, d, oe);
        chk("R10 program failure status", 32'(d), 32'h90);
        wr(24'h0, 16'h0050);
        rd(24'h0, d, oe);
        chk("R9 clear status", 32'(d), 32'h80);
    endtask

    task automatic t_erase;
        logic [DW-1:0] d; logic oe;
        wr(24'h0, 16'h0020);
        wr(24'h030000, 16'h00D0);
        chk("R6 erase start", 32'(eng_start), 32'd1);
        chk("R6 erase kind", 32'(eng_erase), 32'd1);
        chk("R6 erase address", 32'(eng_addr), 32'h030000);
        finish_op(1'b1);
        rd(24'h0, d, oe);
        chk("R10 erase failure status", 32'(d), 32'hA0);
        wr(24'h0, 16'h0050);
        wr(24'h0, 16'h0020);
        wr(24'h0, 16'h0033);
        chk("R8 no start on bad confirm", 32'(eng_start), 32'd0);
        rd(24'h0, d, oe);
        chk("R8 bad confirm status", 32'(d), 32'hB0);
        wr(24'h0, 16'h0050);
        rd(24'h0, d, oe);
        chk("R9 clear keeps status mode", 32'(d), 32'h80);
    endtask

    task automatic t_pen_low;
        logic [DW-1:0] d; logic oe;
        pen = 1'b0;
        wr(24'h0, 16'h0040);
        wr(24'h000010, 16'h1234);
        chk("R7 no program start", 32'(eng_start), 32'd0);
        rd(24'h0, d, oe);
        chk("R7 program pen low status", 32'(d), 32'h98);
        wr(24'h0, 16'h0050);
        wr(24'h0, 16'h0020);
        wr(24'h0, 16'h00D0);
        chk("R7 no erase start", 32'(eng_start), 32'd0);
        rd(24'h0, d, oe);
        chk("R7 erase pen low status", 32'(d), 32'hA8);
        wr(24'h0, 16'h0050);
        pen = 1'b1;
    endtask

    task automatic t_deselect;
        logic [DW-1:0] d; logic oe;
        wr(24'h0, 16'h0040);
        wr(24'h000020, 16'h4242);
        repeat (6) @(negedge clk);
        chk("R13 busy while deselected", 32'(rdy_o), 32'd0);
        wr(24'h0, 16'h00FF);
        finish_op(1'b0);
        chk("R13 ready after deselected finish", 32'(rdy_o), 32'd1);
        rd(24'h000004, d, oe);
        chk("R13 write during op ignored", 32'(d), 32'h80);
    endtask

    task automatic t_powerdown;
        logic [DW-1:0] d; logic oe;
        wr(24'h0, 16'h0040);
        wr(24'h000030, 16'h7777);
        @(negedge clk);
        pd_n = 1'b0;
        ce_n = 3'b000; oe_n = 1'b0;
        #1;
        chk("R11 abort asserted", 32'(eng_abort), 32'd1);
        chk("R11 rdy low", 32'(rdy_o), 32'd0);
        chk("R11 output off", 32'(dq_oe), 32'd0);
        @(negedge clk);
        ce_n = 3'b111; oe_n = 1'b1;
        repeat (2) @(negedge clk);
        pd_n = 1'b1;
        #1 chk("R11 abort released", 32'(eng_abort), 32'd0);
        repeat (BUSY_CYC - 1) @(negedge clk);
        chk("R12 rdy still low", 32'(rdy_o), 32'd0);
        @(negedge clk);
        chk("R12 rdy high after busy time", 32'(rdy_o), 32'd1);
        wr(24'h0, 16'h0090);
        repeat (REC_CYC) @(negedge clk);
        rd(24'h000003, d, oe);
        chk("R12 write in recovery ignored", 32'(d), 32'(16'h0003 ^ 16'hA5A5));
        wr(24'h0, 16'h0070);
        rd(24'h0, d, oe);
        chk("R11 status after power-down", 32'(d), 32'h80);
    endtask

    initial begin
        t_reset();
        t_modes();
        t_gating();
        t_capture();
        t_program();
        t_erase();
        t_pen_low();
        t_deselect();
        t_powerdown();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule